// File: doc/BRIEF.md
# Per-Channel Drain Fault Monitor with Short-Circuit Retry

This block watches the drain of each external low-side power switch and decides whether its gate may be driven. For every channel it takes the commanded on/off state and a digital comparator result. That result is already synchronized to the system clock and is high when the drain voltage sits above its fault threshold. From these the block produces the real gate-drive enable and a live fault flag. All channels are independent copies of the same state machine, and all timing is set by parameters counted in clock cycles.

While a channel is commanded on, a drain that stays high means the load is shorted to supply. Once that is confirmed, the channel does not stay latched off. It enters a retry loop: a long rest with the gate low, then a short probe with the gate high. The loop ends when the command is withdrawn or when a probe finds the drain low again. While a channel is commanded off, a drain that stays low means an open load or a short to ground. Both problems set the same fault flag, and the flag clears as soon as the condition is gone.

Each channel's state machine has five states. ST_IDLE means the command is off and the gate is low. ST_OPEN means the command is off and an open load has been confirmed. ST_DRIVE means the gate is on during normal operation. ST_REST means the gate is held low during a retry. ST_PROBE means the gate is briefly on during a retry.

The transitions are:
- From ST_IDLE: go_drive (command on) leads to ST_DRIVE, and open_confirm (drain low for OPEN_CYC cycles) leads to ST_OPEN.
- From ST_OPEN: go_drive leads to ST_DRIVE, and open_gone (drain high) leads to ST_IDLE.
- From ST_DRIVE: short_confirm (drain high for SHORT_CYC cycles) leads to ST_REST, and cmd_off leads to ST_IDLE.
- From ST_REST: rest_done (after REST_CYC cycles) leads to ST_PROBE, and cmd_off leads to ST_IDLE.
- From ST_PROBE: short_again (drain high for SHORT_CYC cycles) leads to ST_REST, short_gone (drain low) leads to ST_DRIVE, and cmd_off leads to ST_IDLE.

Top module: `hexdrv_fault_monitor`

## Requirements
- R1: While rst_n is low, and after it is released with no stimulus, every gate_o and fault_o bit is 0.
- R2: On a channel with no fault, gate_o follows cmd_i one clock later, both when it rises and when it falls. gate_o is never 1 unless cmd_i was 1 in the previous cycle.
- R3: In ST_DRIVE, SHORT_CYC consecutive cycles with drain_hi_i at 1 drive gate_o to 0 and fault_o to 1 from the next cycle on.
- R4: A single cycle with drain_hi_i at 0 in ST_DRIVE restarts the short filter, so a further full SHORT_CYC run is needed before the short is confirmed.
- R5: After a short is confirmed, gate_o stays 0 for REST_CYC cycles and then goes to 1 for a probe. fault_o stays 1 throughout, and gate_o and fault_o are never both 1 for more than SHORT_CYC cycles in a row.
- R6: A probe that sees drain_hi_i at 1 for SHORT_CYC cycles returns the channel to the rest phase, with gate_o at 0 and fault_o at 1.
- R7: A probe that sees drain_hi_i at 0 returns the channel to normal drive one cycle later, with gate_o at 1 and fault_o at 0.
- R8: Setting cmd_i to 0 at any point in the retry loop sets gate_o and fault_o to 0 one cycle later.
- R9: With cmd_i at 0, OPEN_CYC consecutive cycles with drain_hi_i at 0 set fault_o to 1 while gate_o stays 0. An interruption restarts this filter.
- R10: Open-load detection is inactive while the gate is on: with cmd_i at 1 and drain_hi_i at 0, fault_o stays 0 for any duration.
- R11: With cmd_i at 0, a cycle with drain_hi_i at 1 clears fault_o one cycle later.
- R12: Channels are independent. Bit k of every port belongs to channel k, and a fault on one channel changes no other channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | NCH | Commanded gate state per channel, 1 = on |
| drain_hi_i | input | NCH | Synchronized comparator: 1 = drain above fault threshold |
| gate_o | output | NCH | Actual gate-drive enable per channel |
| fault_o | output | NCH | Live fault flag per channel, 1 = short or open present |

## Verification
The bench builds the block with six channels, SHORT_CYC = 4, OPEN_CYC = 6 and REST_CYC = 20. With these values a full short-to-rest-to-probe retry loop takes only a few dozen cycles. This brings within reach filter restarts, repeated probes, recovery from a probe, open-load confirmation and release, and simultaneous faults on different channels, with every transition timed to the exact cycle.

// File: rtl/hexdrv_pkg.sv
package hexdrv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_OPEN  = 3'd1,
        ST_DRIVE = 3'd2,
        ST_REST  = 3'd3,
        ST_PROBE = 3'd4
    } chan_state_t;

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/hexdrv_timer.sv
module hexdrv_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] lim,
    output logic         hit
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign hit = (cnt_q == lim);

endmodule

// File: rtl/hexdrv_chan_fsm.sv
module hexdrv_chan_fsm
    import hexdrv_pkg::*;
#(
    parameter int unsigned SHORT_CYC = 4,
    parameter int unsigned OPEN_CYC  = 4,
    parameter int unsigned REST_CYC  = 16,
    parameter int unsigned W         = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd,
    input  logic         drain_hi,
    input  logic         tmr_hit,
    output logic         tmr_clr,
    output logic         tmr_inc,
    output logic [W-1:0] tmr_lim,
    output logic         gate,
    output logic         fault
);

    localparam logic [W-1:0] LIM_SHORT = W'(SHORT_CYC - 1);
    localparam logic [W-1:0] LIM_OPEN  = W'(OPEN_CYC - 1);
    localparam logic [W-1:0] LIM_REST  = W'(REST_CYC - 1);

    chan_state_t st_q, st_d;
    logic        done;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Filter limit selected by the current state only
    always_comb begin
        unique case (st_q)
            ST_DRIVE, ST_PROBE: tmr_lim = LIM_SHORT;
            ST_REST:            tmr_lim = LIM_REST;
            default:            tmr_lim = LIM_OPEN;
        endcase
    end

    assign done = tmr_inc && tmr_hit;

    // Counting condition per state
    always_comb begin
        unique case (st_q)
            ST_IDLE:  tmr_inc = !cmd && !drain_hi;
            ST_OPEN:  tmr_inc = 1'b0;
            ST_DRIVE: tmr_inc = cmd && drain_hi;
            ST_REST:  tmr_inc = cmd;
            ST_PROBE: tmr_inc = cmd && drain_hi;
            default:  tmr_inc = 1'b0;
        endcase
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (cmd)       st_d = ST_DRIVE;   // go_drive
                else if (done) st_d = ST_OPEN;    // open_confirm
            end
            ST_OPEN: begin
                if (cmd)           st_d = ST_DRIVE; // go_drive
                else if (drain_hi) st_d = ST_IDLE;  // open_gone
            end
            ST_DRIVE: begin
                if (!cmd)      st_d = ST_IDLE;    // cmd_off
                else if (done) st_d = ST_REST;    // short_confirm
            end
            ST_REST: begin
                if (!cmd)      st_d = ST_IDLE;    // cmd_off
                else if (done) st_d = ST_PROBE;   // rest_done
            end
            ST_PROBE: begin
                if (!cmd)           st_d = ST_IDLE;  // cmd_off
                else if (!drain_hi) st_d = ST_DRIVE; // short_gone
                else if (done)      st_d = ST_REST;  // short_again
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Any state change or broken run restarts the filter
    assign tmr_clr = (st_d != st_q) || !tmr_inc;

    // Output decode
    always_comb begin
        unique case (st_q)
            ST_IDLE:  begin gate = 1'b0; fault = 1'b0; end
            ST_OPEN:  begin gate = 1'b0; fault = 1'b1; end
            ST_DRIVE: begin gate = 1'b1; fault = 1'b0; end
            ST_REST:  begin gate = 1'b0; fault = 1'b1; end
            ST_PROBE: begin gate = 1'b1; fault = 1'b1; end
            default:  begin gate = 1'b0; fault = 1'b0; end
        endcase
    end

endmodule

// File: rtl/hexdrv_chan.sv
module hexdrv_chan #(
    parameter int unsigned SHORT_CYC = 4,
    parameter int unsigned OPEN_CYC  = 4,
    parameter int unsigned REST_CYC  = 16,
    parameter int unsigned W         = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd,
    input  logic drain_hi,
    output logic gate,
    output logic fault
);

    logic         clr, inc, hit;
    logic [W-1:0] lim;

    hexdrv_chan_fsm #(
        .SHORT_CYC (SHORT_CYC),
        .OPEN_CYC  (OPEN_CYC),
        .REST_CYC  (REST_CYC),
        .W         (W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .drain_hi (drain_hi),
        .tmr_hit  (hit),
        .tmr_clr  (clr),
        .tmr_inc  (inc),
        .tmr_lim  (lim),
        .gate     (gate),
        .fault    (fault)
    );

    hexdrv_timer #(.W(W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (inc),
        .lim   (lim),
        .hit   (hit)
    );

endmodule

// File: rtl/hexdrv_fault_monitor.sv
module hexdrv_fault_monitor
    import hexdrv_pkg::*;
#(
    parameter int unsigned NCH       = 6,
    parameter int unsigned SHORT_CYC = 5600,
    parameter int unsigned OPEN_CYC  = 5600,
    parameter int unsigned REST_CYC  = 3280000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cmd_i,
    input  logic [NCH-1:0] drain_hi_i,
    output logic [NCH-1:0] gate_o,
    output logic [NCH-1:0] fault_o
);

    localparam int unsigned MAXC = max3(SHORT_CYC, OPEN_CYC, REST_CYC);
    localparam int unsigned W    = $clog2(MAXC + 1);

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        hexdrv_chan #(
            .SHORT_CYC (SHORT_CYC),
            .OPEN_CYC  (OPEN_CYC),
            .REST_CYC  (REST_CYC),
            .W         (W)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd      (cmd_i[k]),
            .drain_hi (drain_hi_i[k]),
            .gate     (gate_o[k]),
            .fault    (fault_o[k])
        );
    end

endmodule

// File: rtl/hexdrv_fault_checker.sv
module hexdrv_fault_checker #(
    parameter int unsigned NCH       = 6,
    parameter int unsigned SHORT_CYC = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] cmd_i,
    input logic [NCH-1:0] drain_hi_i,
    input logic [NCH-1:0] gate_o,
    input logic [NCH-1:0] fault_o
);

    localparam int unsigned RW = $clog2(SHORT_CYC + 2) + 1;

    for (genvar k = 0; k < NCH; k++) begin : g_chk
        logic [RW-1:0] probe_run;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                probe_run <= '0;
            end else if (gate_o[k] && fault_o[k]) begin
                if (probe_run != {RW{1'b1}}) probe_run <= probe_run + RW'(1);
            end else begin
                probe_run <= '0;
            end
        end

        AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> (!gate_o[k] && !fault_o[k]));  // R1
        AST_GATE_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
            gate_o[k] |-> $past(cmd_i[k]));  // R2
        AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(fault_o[k]) |-> $past((gate_o[k] && drain_hi_i[k]) || (!gate_o[k] && !drain_hi_i[k])));  // R3
        AST_PROBE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
            probe_run <= RW'(SHORT_CYC));  // R5
        AST_CMD_OFF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            !cmd_i[k] |=> !gate_o[k]);  // R8
        AST_OFF_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (!cmd_i[k] && drain_hi_i[k]) |=> !fault_o[k]);  // R11
    end

endmodule

bind hexdrv_fault_monitor hexdrv_fault_checker #(
    .NCH       (NCH),
    .SHORT_CYC (SHORT_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_i      (cmd_i),
    .drain_hi_i (drain_hi_i),
    .gate_o     (gate_o),
    .fault_o    (fault_o)
);

// File: tb/hexdrv_fault_monitor_test.sv
`timescale 1ns/1ps
module hexdrv_fault_monitor_test;

    localparam int NCH = 6;
    localparam int SH  = 4;
    localparam int OP  = 6;
    localparam int RS  = 20;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] cmd;
    logic [NCH-1:0] drn;
    logic [NCH-1:0] gate;
    logic [NCH-1:0] fault;

    int checks = 0;
    int fails  = 0;

    logic [2*NCH-1:0] exp_q[$];
    string            tag_q[$];

    always #2.5 clk = ~clk;

    hexdrv_fault_monitor #(
        .NCH       (NCH),
        .SHORT_CYC (SH),
        .OPEN_CYC  (OP),
        .REST_CYC  (RS)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (cmd),
        .drain_hi_i (drn),
        .gate_o     (gate),
        .fault_o    (fault)
    );

    // Driver: apply inputs at the falling edge, queue the result due after the next rising edge
    task automatic drive(input logic [NCH-1:0] c, input logic [NCH-1:0] d,
                         input logic [NCH-1:0] g, input logic [NCH-1:0] f,
                         input string tag);
        @(negedge clk);
        cmd = c;
        drn = d;
        exp_q.push_back({g, f});
        tag_q.push_back(tag);
    endtask

    // Channel 0 only; others off with drain high (expected quiet)
    task automatic d0(input logic c, input logic d, input logic g, input logic f,
                      input string tag);
        drive({{(NCH-1){1'b0}}, c}, {{(NCH-1){1'b1}}, d},
              {{(NCH-1){1'b0}}, g}, {{(NCH-1){1'b0}}, f}, tag);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Monitor: compare one queued item per rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [2*NCH-1:0] e;
                string            t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (t != "") begin
                    checks++;
                    if ({gate, fault} !== e) begin
                        fails++;
                        $display("FAIL %s gate=%b fault=%b expected gate=%b fault=%b",
                                 t, gate, fault, e[2*NCH-1:NCH], e[NCH-1:0]);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run still active, expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cmd   = '0;
        drn   = '1;
        repeat (3) begin
            @(negedge clk);
            checks++;
            if (gate !== '0 || fault !== '0) begin
                fails++;
                $display("FAIL R1 gate=%b fault=%b expected gate=0 fault=0", gate, fault);
            end
        end
        rst_n = 1'b1;
        d0(0, 1, 0, 0, "R1 idle after reset");

        // R2: gate follows command
        d0(1, 0, 1, 0, "R2 gate rises");
        for (int i = 0; i < 3; i++) d0(1, 0, 1, 0, "R2 gate holds");
        d0(0, 1, 0, 0, "R2 gate falls");

        // R4 then R3: interrupted run, then full run
        d0(1, 0, 1, 0, "R2 gate rises again");
        for (int i = 0; i < SH - 1; i++) d0(1, 1, 1, 0, "R3 filtering");
        d0(1, 0, 1, 0, "R4 glitch low");
        for (int i = 0; i < SH - 1; i++) d0(1, 1, 1, 0, "R4 restarted filter");
        d0(1, 1, 0, 1, "R3 short confirmed");

        // R5: rest then probe
        for (int i = 0; i < RS - 1; i++) d0(1, 1, 0, 1, "R5 resting");
        d0(1, 1, 1, 1, "R5 probe starts");
        // R6: probe still shorted
        for (int i = 0; i < SH - 1; i++) d0(1, 1, 1, 1, "R6 probing");
        d0(1, 1, 0, 1, "R6 back to rest");
        for (int i = 0; i < RS - 1; i++) d0(1, 1, 0, 1, "R5 resting again");
        d0(1, 1, 1, 1, "R5 second probe");
        // R7: short gone during probe
        d0(1, 0, 1, 0, "R7 recovered");
        for (int i = 0; i < 2; i++) d0(1, 0, 1, 0, "R7 normal drive");

        // R8: command off inside retry
        for (int i = 0; i < SH - 1; i++) d0(1, 1, 1, 0, "R3 filtering");
        d0(1, 1, 0, 1, "R3 short confirmed");
        for (int i = 0; i < 5; i++) d0(1, 1, 0, 1, "R5 resting");
        d0(0, 1, 0, 0, "R8 command off exits retry");
        for (int i = 0; i < 3; i++) d0(0, 1, 0, 0, "R8 stays idle");

        // R9/R11: open load
        for (int i = 0; i < OP - 1; i++) d0(0, 0, 0, 0, "R9 open filtering");
        d0(0, 0, 0, 1, "R9 open confirmed");
        for (int i = 0; i < 2; i++) d0(0, 0, 0, 1, "R9 open held");
        d0(0, 1, 0, 0, "R11 open cleared");
        for (int i = 0; i < 3; i++) d0(0, 0, 0, 0, "R9 open filtering");
        d0(0, 1, 0, 0, "R9 interruption");
        for (int i = 0; i < OP - 1; i++) d0(0, 0, 0, 0, "R9 restarted filter");
        d0(0, 0, 0, 1, "R9 open confirmed again");

        // R10: no open detection while on
        d0(1, 0, 1, 0, "R10 drive from open");
        for (int i = 0; i < 10; i++) d0(1, 0, 1, 0, "R10 no open while on");
        d0(0, 1, 0, 0, "R2 off");

        // R12: ch0 normal, ch2 short, ch3 open
        for (int i = 0; i < SH; i++)
            drive(6'b000101, 6'b110110, 6'b000101, 6'b000000, "R12 concurrent");
        drive(6'b000101, 6'b110110, 6'b000001, 6'b000100, "R12 ch2 short only");
        drive(6'b000101, 6'b110110, 6'b000001, 6'b001100, "R12 ch3 open added");
        drive(6'b000000, 6'b111111, 6'b000000, 6'b000000, "R12 all released");

        repeat (3) @(posedge clk);
        #2;
        summary();
        $finish;
    end

endmodule